// File: doc/BRIEF.md
# Power-Event Interrupt and RAM-Clear Controller

This block holds the control logic behind one 8-bit extended control register of a real-time-clock device. It latches two power-event flags: a wake flag, set by an alarm-match pulse, and a kick flag, set by a kickstart pulse. It drives an active-low interrupt output and an active-low power-control output. How these outputs respond depends on whether main supply is present.

It also watches an active-low RAM-clear pin. When clearing is enabled, a falling edge on that pin starts a sequencer that writes zero to every byte of the user RAM through a simple write port, one byte per clock. When the sweep finishes, a done flag is set, and that flag can raise the interrupt.

A CPU-side register port selects between the control register and a status register. Reading the status register clears the flags.

Top module: `rtc_pwr_evt`

## Requirements
- R1: The control register resets to 0 and is written when reg_wr=1 and reg_sel=0. It reads back on reg_rdata when reg_sel=0. Its bits are: [7] aux enable, [6] fast square-wave select, [5] crystal load select, [4] clear enable, [3] power-output hold, [2] clear interrupt enable, [1] wake enable, [0] kick enable. Bits 7, 6 and 5 appear directly on aux_en, sqw_fast and xtal_load.
- R2: A high wake_pulse at a clock edge sets the wake flag, and a high kick_pulse sets the kick flag, whatever the enables are. With reg_sel=1, reg_rdata reads {5'b0, done, kick, wake}. Writes with reg_sel=1 are ignored.
- R3: pwr_n is low exactly while (wake flag and wake enable) or (kick flag and kick enable) holds, whether or not main supply is present.
- R4: irq_n is low exactly while main_pwr=1 and at least one of these holds: (wake flag and wake enable), (kick flag and kick enable), (done flag and clear interrupt enable). A flag whose enable is 0 has no effect on either output.
- R5: With clear enable=1, a falling edge of clr_pin_n sampled at a clock edge starts a sweep. From the next cycle, ram_we=1 for 114 consecutive cycles, with ram_addr running 0 to 113 and ram_wdata=0.
- R6: With clear enable=0, a falling edge of clr_pin_n is ignored and no write occurs.
- R7: A falling edge of clr_pin_n during an active sweep is ignored. The sweep neither restarts nor stretches.
- R8: The done flag is set at the clock edge that completes the write to address 113.
- R9: A status read (reg_rd=1, reg_sel=1) clears the wake, kick and done flags at the end of that cycle. A flag set in the same cycle stays set.
- R10: pwr_oe is high while main_pwr=1 or the power-output hold bit is 1. Otherwise it is low, which models the high-impedance state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| main_pwr | input | 1 | Main supply present |
| wake_pulse | input | 1 | Wake alarm match |
| kick_pulse | input | 1 | Kickstart event |
| clr_pin_n | input | 1 | Active-low RAM-clear request pin |
| reg_sel | input | 1 | 0 selects control, 1 selects status |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| irq_n | output | 1 | Active-low interrupt |
| pwr_n | output | 1 | Active-low power-control |
| pwr_oe | output | 1 | Output enable of pwr_n |
| aux_en | output | 1 | Control bit 7 |
| sqw_fast | output | 1 | Control bit 6 |
| xtal_load | output | 1 | Control bit 5 |
| ram_we | output | 1 | User RAM write enable |
| ram_addr | output | 7 | User RAM address |
| ram_wdata | output | 8 | User RAM write data (zero) |

## Verification
The flags, the control register and the sweep state each change one clock edge after their input is sampled. irq_n, pwr_n and pwr_oe follow that state combinationally, and irq_n and pwr_oe also follow main_pwr in the same cycle. The first RAM write appears in the cycle after the pin edge is sampled, and the done flag appears in the cycle after the write to address 113.

The bench drives inputs shortly after each rising edge and advances its reference model on that same edge. It compares every output at the falling edge, so each expected value is read at the cycle it is due. Directed checks then count the writes per sweep and the zeroed bytes, and probe flag clearing by reading the status register.

// File: rtl/rtc_pwr_evt.sv
module rtc_pwr_evt #(
  parameter int RAM_BYTES = 114,
  parameter int DW = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          main_pwr,
  input  logic                          wake_pulse,
  input  logic                          kick_pulse,
  input  logic                          clr_pin_n,
  input  logic                          reg_sel,
  input  logic                          reg_wr,
  input  logic                          reg_rd,
  input  logic [7:0]                    reg_wdata,
  output logic [7:0]                    reg_rdata,
  output logic                          irq_n,
  output logic                          pwr_n,
  output logic                          pwr_oe,
  output logic                          aux_en,
  output logic                          sqw_fast,
  output logic                          xtal_load,
  output logic                          ram_we,
  output logic [$clog2(RAM_BYTES)-1:0]  ram_addr,
  output logic [DW-1:0]                 ram_wdata
);
  localparam int AW = $clog2(RAM_BYTES);
  localparam logic [AW-1:0] LAST = AW'(RAM_BYTES - 1);

  logic [7:0]    ctrl;
  logic          wf, kf, done, busy, pin_q;
  logic [AW-1:0] addr;

  wire stat_rd = reg_rd & reg_sel;
  wire at_last = addr == LAST;
  wire fall    = pin_q & ~clr_pin_n;
  wire evt_act = (wf & ctrl[1]) | (kf & ctrl[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl  <= '0;
      wf    <= 1'b0;
      kf    <= 1'b0;
      done  <= 1'b0;
      busy  <= 1'b0;
      addr  <= '0;
      pin_q <= 1'b1;
    end else begin
      if (reg_wr && !reg_sel) ctrl <= reg_wdata;
      wf    <= (wf & ~stat_rd) | wake_pulse;
      kf    <= (kf & ~stat_rd) | kick_pulse;
      done  <= (done & ~stat_rd) | (busy & at_last);
      pin_q <= clr_pin_n;
      if (busy) begin
        if (at_last) busy <= 1'b0;
        else         addr <= addr + 1'b1;
      end else if (fall && ctrl[4]) begin
        busy <= 1'b1;
        addr <= '0;
      end
    end
  end

  assign reg_rdata = reg_sel ? {5'b0, done, kf, wf} : ctrl;
  assign pwr_n     = ~evt_act;
  assign irq_n     = ~(main_pwr & (evt_act | (done & ctrl[2])));
  assign pwr_oe    = main_pwr | ctrl[3];
  assign aux_en    = ctrl[7];
  assign sqw_fast  = ctrl[6];
  assign xtal_load = ctrl[5];
  assign ram_we    = busy;
  assign ram_addr  = addr;
  assign ram_wdata = '0;
endmodule

module rtc_pwr_evt_chk #(
  parameter int AW = 7,
  parameter int LASTI = 113
) (
  input logic          clk,
  input logic          rst_n,
  input logic          main_pwr,
  input logic [7:0]    ctrl,
  input logic          wf,
  input logic          kf,
  input logic          irq_n,
  input logic          pwr_n,
  input logic          pwr_oe,
  input logic          ram_we,
  input logic [AW-1:0] ram_addr,
  input logic          done
);
  // R4
  irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !main_pwr |-> irq_n);
  // R10
  pwr_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!main_pwr && !ctrl[3]) |-> !pwr_oe);
  // R3
  pwr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_n |-> ((wf && ctrl[1]) || (kf && ctrl[0])));
  // R5
  sweep_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && ram_addr != AW'(LASTI)) |=> (ram_we && ram_addr == $past(ram_addr) + 1'b1));
  // R8
  sweep_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && ram_addr == AW'(LASTI)) |=> (!ram_we && done));
  // R6
  no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_we && !ctrl[4]) |=> !ram_we);
endmodule

bind rtc_pwr_evt rtc_pwr_evt_chk #(.AW(AW), .LASTI(RAM_BYTES - 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .main_pwr(main_pwr), .ctrl(ctrl), .wf(wf), .kf(kf),
  .irq_n(irq_n), .pwr_n(pwr_n), .pwr_oe(pwr_oe), .ram_we(ram_we),
  .ram_addr(ram_addr), .done(done)
);

// File: tb/test_rtc_pwr_evt.sv
module test_rtc_pwr_evt;
  localparam int NB = 114;
  logic clk = 0, rst_n = 0;
  logic main_pwr = 1, wake_pulse = 0, kick_pulse = 0, clr_pin_n = 1;
  logic reg_sel = 0, reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic irq_n, pwr_n, pwr_oe, aux_en, sqw_fast, xtal_load, ram_we;
  logic [6:0] ram_addr;
  logic [7:0] ram_wdata;

  int total = 0, bad = 0, writes = 0;
  int m_ctrl = 0, m_wf = 0, m_kf = 0, m_done = 0, m_busy = 0, m_addr = 0, m_pin = 1;
  int mem [NB];

  always #5 clk = ~clk;

  rtc_pwr_evt i_rtc_pwr_evt (.*);

  task automatic chk(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h t=%0t", req, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_wf = 0; m_kf = 0; m_done = 0; m_busy = 0; m_addr = 0; m_pin = 1;
    end else begin
      int rdc, fall;
      rdc  = reg_rd && reg_sel;
      fall = m_pin && !clr_pin_n;
      if (reg_wr && !reg_sel) m_ctrl = reg_wdata;
      m_wf   = (m_wf && !rdc) || wake_pulse;
      m_kf   = (m_kf && !rdc) || kick_pulse;
      m_done = (m_done && !rdc) || (m_busy && m_addr == NB - 1);
      if (m_busy) begin
        if (m_addr == NB - 1) m_busy = 0; else m_addr++;
      end else if (fall && m_ctrl[4]) begin
        m_busy = 1; m_addr = 0;
      end
      m_pin = clr_pin_n;
    end
  end

  always @(negedge clk) if (rst_n) begin
    int evt, irq;
    evt = (m_wf && m_ctrl[1]) || (m_kf && m_ctrl[0]);
    irq = main_pwr && (evt || (m_done && m_ctrl[2]));
    chk("R1 ctrl outs", {aux_en, sqw_fast, xtal_load}, m_ctrl[7:5]);
    chk(reg_sel ? "R2 status rd" : "R1 ctrl rd", reg_rdata,
        reg_sel ? (m_done * 4 + m_kf * 2 + m_wf) : m_ctrl);
    chk("R3 pwr_n", pwr_n, !evt);
    chk("R4 irq_n", irq_n, !irq);
    chk("R10 pwr_oe", pwr_oe, main_pwr || m_ctrl[3]);
    chk("R5 ram_we", ram_we, m_busy);
    if (ram_we) begin
      chk("R5 ram_addr", ram_addr, m_addr);
      chk("R5 ram_wdata", ram_wdata, 0);
      writes++;
      if (ram_addr < NB) mem[ram_addr] = ram_wdata;
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr_ctrl(int v);
    reg_sel = 0; reg_wr = 1; reg_wdata = 8'(v);
    step(); reg_wr = 0;
  endtask

  task automatic rd_status(string req, int exp);
    reg_sel = 1; reg_rd = 1;
    @(negedge clk); chk(req, reg_rdata, exp);
    step(); reg_rd = 0; reg_sel = 0;
  endtask

  initial begin
    #1_500_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    foreach (mem[i]) mem[i] = 8'hA5;
    step(3); rst_n = 1; step();
    @(negedge clk);
    chk("R1 reset ctrl", reg_rdata, 0);
    chk("R3 reset pwr_n", pwr_n, 1);
    chk("R4 reset irq_n", irq_n, 1);
    step();
    // R1 field outputs
    wr_ctrl(8'hE0);
    @(negedge clk); chk("R1 outs", {aux_en, sqw_fast, xtal_load}, 7);
    step();
    // R3 R4 wake with main present
    wr_ctrl(8'h03);
    wake_pulse = 1; step(); wake_pulse = 0;
    @(negedge clk); chk("R3 wake pwr_n", pwr_n, 0); chk("R4 wake irq_n", irq_n, 0);
    step();
    rd_status("R9 read wake", 1);
    @(negedge clk); chk("R9 cleared irq", irq_n, 1);
    step();
    // kick with main absent
    main_pwr = 0; kick_pulse = 1; step(); kick_pulse = 0;
    @(negedge clk); chk("R3 kick pwr_n", pwr_n, 0); chk("R4 no irq off-supply", irq_n, 1);
    chk("R10 hiz", pwr_oe, 0);
    step(); main_pwr = 1;
    @(negedge clk); chk("R4 irq on supply return", irq_n, 0);
    step();
    rd_status("R2 kick flag", 2);
    // disabled flags
    wr_ctrl(8'h00);
    wake_pulse = 1; kick_pulse = 1; step(); wake_pulse = 0; kick_pulse = 0;
    @(negedge clk); chk("R4 disabled irq", irq_n, 1); chk("R3 disabled pwr", pwr_n, 1);
    step();
    rd_status("R2 flags set anyway", 3);
    // R2 status write ignored
    reg_sel = 1; reg_wr = 1; reg_wdata = 8'h5A; step(); reg_wr = 0; reg_sel = 0;
    @(negedge clk); chk("R2 status write ignored", reg_rdata, 0);
    step();
    // R9 same-cycle set wins
    wr_ctrl(8'h02);
    reg_sel = 1; reg_rd = 1; wake_pulse = 1; step(); reg_rd = 0; wake_pulse = 0;
    @(negedge clk); chk("R9 set wins", reg_rdata, 1); chk("R9 pwr still", pwr_n, 0);
    step();
    reg_sel = 0;
    rd_status("R9 read", 1);
    // R10 hold
    wr_ctrl(8'h08); main_pwr = 0; step();
    @(negedge clk); chk("R10 hold", pwr_oe, 1);
    step(); main_pwr = 1;
    // R6 clear disabled
    wr_ctrl(8'h00);
    writes = 0; clr_pin_n = 0; step(150); clr_pin_n = 1; step(2);
    chk("R6 no writes", writes, 0);
    // R5 R7 R8 sweep
    wr_ctrl(8'h14);
    writes = 0; clr_pin_n = 0; step(1);
    @(negedge clk); chk("R5 first write", ram_we, 1);
    step(20); clr_pin_n = 1; step(3); clr_pin_n = 0; step(3); clr_pin_n = 1;
    step(100);
    chk("R7 write count", writes, NB);
    begin
      int nz = 0;
      foreach (mem[i]) if (mem[i] != 0) nz++;
      chk("R5 all zero", nz, 0);
    end
    @(negedge clk); chk("R8 done irq", irq_n, 0);
    step();
    rd_status("R8 done flag", 4);
    @(negedge clk); chk("R9 done cleared", irq_n, 1);
    step(3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule